// File: doc/BRIEF.md
# Parallel Reed-Solomon Syndrome Calculator

This block is the first stage of a Reed-Solomon decoder for a code of length 528 with 514 message symbols over GF(2^10), which corrects up to seven symbol errors. It evaluates the received codeword polynomial at the fourteen code roots. Symbols arrive as a wide slice of P ten-bit symbols per clock, and each of the fourteen accumulators advances by a whole slice in every cycle. The accumulator first multiplies its running value by the root raised to the power P·j. It then adds the slice, with each symbol weighted by its position inside the slice.

A codeword is opened by a start flag on its first slice. The block then takes N/P valid slices: 33 at the default of 16 symbols per clock and 8 in the 66-symbols-per-clock build. One cycle after the final slice it raises a single-cycle done pulse and presents all fourteen syndromes. At the same time it gives a flag that is high only when every syndrome is zero, so the later decoder stages can be skipped for a clean codeword. The results stay on the outputs until the next codeword completes. The next codeword may start on the cycle right after the last slice of the previous one.

Top module: `rs_syn_calc`

## Requirements
- R1: While reset is asserted and after reset is released, `outDone`, `outZero` and `outSyn` are all zero until the first codeword completes.
- R2: Symbol i of a slice sits at `inData[10*i+9:10*i]`, and it is received before symbol i+1. The first symbol received is the coefficient of x^527. With field polynomial x^10+x^3+1 and alpha = 0x002, the field `outSyn[10*j+9:10*j]` equals c(alpha^j) for j = 0..13.
- R3: `outDone` is high for exactly one cycle, the cycle after the clock edge that absorbs the (N/P)-th valid slice of a codeword. N/P is 33 for P=16 and 8 for P=66, and `outDone` stays low after every earlier slice.
- R4: While `outDone` is high, `outZero` is 1 exactly when all fourteen syndromes are zero. This includes nonzero codewords that are multiples of the generator polynomial.
- R5: A cycle with `inValid` low inside a codeword is a stall. It changes neither the result nor the slice count.
- R6: A slice with `inValid` high and `inStart` low that arrives while no codeword is open is ignored. It raises no `outDone` and leaves the outputs unchanged.
- R7: A start flag that arrives inside an open codeword drops the partial result. The block restarts the count from that slice.
- R8: A new codeword may start on the cycle right after the last slice of the previous codeword, and both results are correct.
- R9: `outSyn` and `outZero` hold their values in every cycle in which `outDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Slice on `inData` is valid this cycle |
| inStart | input | 1 | Slice is the first of a codeword |
| inData | input | 10*P | P symbols; symbol 0 earliest |
| outDone | output | 1 | Single-cycle result strobe |
| outZero | output | 1 | All syndromes zero for last codeword |
| outSyn | output | 140 | Fourteen syndromes, S0 in the low bits |

## Verification
The bench builds two copies of the block at the same time: one with the default 16 symbols per clock and one with 66 symbols per clock. Both take the same codeword contents, so the 33-slice and the 8-slice result timing are checked against one reference that works one symbol at a time. At 16 symbols per clock there is enough room to insert stalls, to send codewords back to back, and to abort a codeword partway through. Single symbols placed at the first and last positions check the slice ordering and the weight given to each position. Shifted copies of the generator polynomial exercise the zero flag on codewords whose data is not zero.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int SYM_W = 10;
  localparam int FIELD_ORDER = (1 << SYM_W) - 1;
  // low taps of x^10 + x^3 + 1
  localparam logic [SYM_W-1:0] FIELD_TAPS = 10'h009;

  typedef struct packed {
    logic load;    // first slice: replace accumulator
    logic accum;   // later slice: fold into accumulator
    logic finish;  // this slice completes the codeword
  } synStrobe_t;

  function automatic logic [SYM_W-1:0] gfXtime(input logic [SYM_W-1:0] a);
    gfXtime = {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_TAPS : '0);
  endfunction

  function automatic logic [SYM_W-1:0] gfMul(input logic [SYM_W-1:0] a,
                                             input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] r;
    r = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      r = gfXtime(r) ^ (b[k] ? a : '0);
    end
    gfMul = r;
  endfunction

  function automatic logic [SYM_W-1:0] gfPow(input int e);
    logic [SYM_W-1:0] r;
    int red;
    red = e % FIELD_ORDER;
    r = {{(SYM_W-1){1'b0}}, 1'b1};
    for (int k = 0; k < red; k++) begin
      r = gfXtime(r);
    end
    gfPow = r;
  endfunction

endpackage

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
  import rs_syn_pkg::*;
#(
  parameter int NBLK = 33
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  output synStrobe_t strobe
);

  localparam int CW = (NBLK < 2) ? 1 : $clog2(NBLK + 1);
  localparam bit ONE_BLK = (NBLK == 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(NBLK - 1);

  logic [CW-1:0] sliceCnt;
  logic          openCw;

  assign openCw = (sliceCnt != '0);

  always_comb begin
    strobe.load   = inValid && inStart;
    strobe.accum  = inValid && !inStart && openCw;
    strobe.finish = (strobe.load && ONE_BLK) ||
                    (strobe.accum && (sliceCnt == LAST_CNT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sliceCnt <= '0;
    end else if (strobe.finish) begin
      sliceCnt <= '0;
    end else if (strobe.load) begin
      sliceCnt <= CW'(1);
    end else if (strobe.accum) begin
      sliceCnt <= sliceCnt + CW'(1);
    end
  end

endmodule

// File: rtl/rs_syn_lane.sv
module rs_syn_lane
  import rs_syn_pkg::*;
#(
  parameter int P = 16,
  parameter int J = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [P*SYM_W-1:0]   slice,
  input  synStrobe_t           strobe,
  output logic [SYM_W-1:0]     accNext
);

  localparam logic [SYM_W-1:0] STEP = gfPow(P * J);

  logic [SYM_W-1:0] acc;
  logic [SYM_W-1:0] prod [P];
  logic [SYM_W-1:0] sliceSum;
  logic [SYM_W-1:0] carried;

  for (genvar i = 0; i < P; i++) begin : g_term
    localparam logic [SYM_W-1:0] WEIGHT = gfPow(J * (P - 1 - i));
    assign prod[i] = gfMul(slice[i*SYM_W +: SYM_W], WEIGHT);
  end

  always_comb begin
    sliceSum = '0;
    for (int i = 0; i < P; i++) begin
      sliceSum = sliceSum ^ prod[i];
    end
    carried = strobe.load ? '0 : gfMul(acc, STEP);
    accNext = carried ^ sliceSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.load || strobe.accum) begin
      acc <= accNext;
    end
  end

endmodule

// File: rtl/rs_syn_dpath.sv
module rs_syn_dpath
  import rs_syn_pkg::*;
#(
  parameter int P    = 16,
  parameter int NSYN = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [P*SYM_W-1:0]      slice,
  input  synStrobe_t              strobe,
  output logic                    outDone,
  output logic                    outZero,
  output logic [NSYN*SYM_W-1:0]   outSyn
);

  logic [NSYN*SYM_W-1:0] allNext;

  for (genvar j = 0; j < NSYN; j++) begin : g_lane
    rs_syn_lane #(.P(P), .J(j)) uLane (
      .clk    (clk),
      .rstN   (rstN),
      .slice  (slice),
      .strobe (strobe),
      .accNext(allNext[j*SYM_W +: SYM_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outDone <= 1'b0;
      outZero <= 1'b0;
      outSyn  <= '0;
    end else begin
      outDone <= strobe.finish;
      if (strobe.finish) begin
        outSyn  <= allNext;
        outZero <= (allNext == '0);
      end
    end
  end

endmodule

// File: rtl/rs_syn_calc.sv
module rs_syn_calc
  import rs_syn_pkg::*;
#(
  parameter int N = 528,
  parameter int P = 16,
  parameter int T = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inStart,
  input  logic [P*SYM_W-1:0]       inData,
  output logic                     outDone,
  output logic                     outZero,
  output logic [2*T*SYM_W-1:0]     outSyn
);

  localparam int NSYN = 2 * T;
  localparam int NBLK = N / P;

  if (NBLK * P != N) begin : g_bad_p
    initial $error("slice width must divide codeword length");
  end

  synStrobe_t strobe;

  rs_syn_ctrl #(.NBLK(NBLK)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inStart(inStart),
    .strobe (strobe)
  );

  rs_syn_dpath #(.P(P), .NSYN(NSYN)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .slice  (inData),
    .strobe (strobe),
    .outDone(outDone),
    .outZero(outZero),
    .outSyn (outSyn)
  );

endmodule

// File: rtl/rs_syn_calc_chk.sv
module rs_syn_calc_chk #(
  parameter int N   = 528,
  parameter int P   = 16,
  parameter int SW  = 140
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          outDone,
  input logic          outZero,
  input logic [SW-1:0] outSyn
);

  localparam bit MULTI = (N / P) > 1;

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (MULTI && outDone) |=> !outDone);

  assert_done_after_input_R3: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> $past(inValid));

  assert_zero_matches_R4: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> (outZero == (outSyn == '0)));

  assert_syn_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outDone |-> $stable(outSyn));

  assert_zero_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outDone |-> $stable(outZero));

endmodule

bind rs_syn_calc rs_syn_calc_chk #(.N(N), .P(P), .SW(2*T*10)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .inValid(inValid),
  .outDone(outDone),
  .outZero(outZero),
  .outSyn (outSyn)
);

// File: tb/sim_rs_syn_calc.sv
module sim_rs_syn_calc;

  localparam int CLK_PERIOD = 10;
  localparam int N = 528;
  localparam int NV = 6;
  // kind: 0 zero word, 1 single symbol at arg, 2 random seed arg, 3 generator shifted by arg
  localparam int VKIND [NV] = '{0, 1, 1, 2, 3, 3};
  localparam int VARG  [NV] = '{0, 0, 527, 12345, 0, 200};
  localparam bit VGAP  [NV] = '{0, 0, 1, 0, 0, 1};

  logic clk = 0;
  logic rstN = 0;
  logic v16 = 0, s16 = 0, v66 = 0, s66 = 0;
  logic [159:0] d16 = '0;
  logic [659:0] d66 = '0;
  logic done16, zero16, done66, zero66;
  logic [139:0] syn16, syn66;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  logic [9:0] sym [N];
  logic [9:0] expT [1023];
  int logT [1024];
  logic [139:0] expSyn;
  bit expZero;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_syn_calc #(.N(N), .P(16), .T(7)) u0 (
    .clk(clk), .rstN(rstN), .inValid(v16), .inStart(s16), .inData(d16),
    .outDone(done16), .outZero(zero16), .outSyn(syn16));

  rs_syn_calc #(.N(N), .P(66), .T(7)) u1 (
    .clk(clk), .rstN(rstN), .inValid(v66), .inStart(s66), .inData(d66),
    .outDone(done66), .outZero(zero66), .outSyn(syn66));

  function automatic logic [9:0] gm(input logic [9:0] a, input logic [9:0] b);
    if (a == 0 || b == 0) return 10'd0;
    return expT[(logT[a] + logT[b]) % 1023];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [139:0] act,
                     input logic [139:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model();
    logic [9:0] s;
    expSyn = '0;
    for (int j = 0; j < 14; j++) begin
      s = 0;
      for (int p = 0; p < N; p++) s = gm(s, expT[j]) ^ sym[p];
      expSyn[j*10 +: 10] = s;
    end
    expZero = (expSyn == '0);
  endtask

  task automatic fill(input int kind, input int arg);
    logic [31:0] x;
    logic [9:0] g [15];
    for (int p = 0; p < N; p++) sym[p] = 0;
    if (kind == 1) sym[arg] = 10'h2A5;
    if (kind == 2) begin
      x = arg;
      for (int p = 0; p < N; p++) begin
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        sym[p] = x[9:0];
      end
    end
    if (kind == 3) begin
      for (int m = 0; m < 15; m++) g[m] = 0;
      g[0] = 1;
      for (int j = 0; j < 14; j++)
        for (int m = j + 1; m >= 0; m--)
          g[m] = (m > 0 ? g[m-1] : 10'd0) ^ gm(g[m], expT[j]);
      for (int m = 0; m < 15; m++) sym[N-1-m-arg] = g[m];
    end
    model();
  endtask

  task automatic drive(input int p, input bit v, input bit s, input int b);
    if (p == 16) begin
      v16 = v; s16 = s;
      for (int i = 0; i < 16; i++) d16[i*10 +: 10] = sym[(b*16 + i) % N];
    end else begin
      v66 = v; s66 = s;
      for (int i = 0; i < 66; i++) d66[i*10 +: 10] = sym[(b*66 + i) % N];
    end
  endtask

  function automatic bit doneOf(input int p);
    return (p == 16) ? done16 : done66;
  endfunction

  // sends a full codeword; leaves the check at the negedge after the last slice
  task automatic runCw(input int p, input bit gap, input string tag);
    int nb = N / p;
    bit early = 0;
    logic [139:0] act;
    bit az;
    for (int b = 0; b < nb; b++) begin
      drive(p, 1, b == 0, b);
      @(negedge clk);
      if (b < nb - 1 && doneOf(p)) early = 1;
      if (gap && b < nb - 1) begin
        drive(p, 0, 0, b);
        @(negedge clk);
        if (doneOf(p)) early = 1;
      end
    end
    act = (p == 16) ? syn16 : syn66;
    az  = (p == 16) ? zero16 : zero66;
    chk(doneOf(p) && !early, {"R3 done timing ", tag}, {139'd0, doneOf(p)}, 140'd1);
    chk(act == expSyn, {"R2 syndromes ", tag}, act, expSyn);
    chk(az == expZero, {"R4 zero flag ", tag}, {139'd0, az}, {139'd0, expZero});
    drive(p, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [139:0] keep;
    bit seen;
    expT[0] = 1;
    for (int i = 1; i < 1023; i++)
      expT[i] = {expT[i-1][8:0], 1'b0} ^ (expT[i-1][9] ? 10'h009 : 10'h000);
    for (int i = 0; i < 1023; i++) logT[expT[i]] = i;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!done16 && !zero16 && syn16 == '0, "R1 reset u0", syn16, '0);
    rstN = 1;
    @(negedge clk);
    chk(!done66 && !zero66 && syn66 == '0, "R1 after release u1", syn66, '0);

    // table walk: P=16 back to back (R8), then P=66
    for (int v = 0; v < NV; v++) begin
      fill(VKIND[v], VARG[v]);
      runCw(16, VGAP[v], $sformatf("p16 vec%0d R5 R8", v));
    end
    for (int v = 0; v < NV; v++) begin
      fill(VKIND[v], VARG[v]);
      runCw(66, 1'b0, $sformatf("p66 vec%0d", v));
    end

    // R9 hold after done
    fill(2, 777);
    runCw(16, 0, "R9 setup");
    keep = syn16;
    repeat (6) @(negedge clk);
    chk(syn16 == expSyn && zero16 == expZero, "R9 hold", syn16, expSyn);

    // R6 valid without start while idle is ignored
    seen = 0;
    fill(2, 999);
    for (int b = 0; b < 5; b++) begin
      drive(16, 1, 0, b);
      @(negedge clk);
      if (done16) seen = 1;
    end
    drive(16, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(!seen && !done16, "R6 no done", {139'd0, seen}, '0);
    chk(syn16 == keep, "R6 outputs unchanged", syn16, keep);

    // R7 restart mid-codeword
    fill(2, 4242);
    for (int b = 0; b < 10; b++) begin
      drive(16, 1, b == 0, b);
      @(negedge clk);
    end
    fill(3, 37);
    runCw(16, 0, "R7 restart");
    fill(1, 300);
    runCw(16, 0, "R7 after restart");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule